// File: doc/BRIEF.md
# Condition Code Flag Update Unit

This block produces the negative, zero, overflow and carry flags that follow an ALU operation, for byte and word results. The ALU supplies both operands, the result it computed, a width select and an operation class. The block then applies the update rule for that class: add, subtract, test or shift. Carry and overflow are taken from the sign bits of the operands and the result, so no carry chain has to come out of the adder. Subtract uses the borrow convention, where a set carry means a borrow occurred.

The current 8-bit flag register enters on `ccr_in`. The updated value is captured into `ccr_q` on the clock edge where `upd_en` is high. The four upper bits (S, X, H, I) pass through unchanged. Half-carry, decimal adjust and the datapath itself belong to neighbouring logic.

Top module: `ccr_flag_unit`

## Requirements
- R1: While `rst_n` is low, `ccr_q` equals the parameter `RST_CCR` (default 8'hD0).
- R2: On a clock edge with `upd_en` low, `ccr_q` keeps its value whatever the other inputs do.
- R3: Bit layout, MSB first: S(7) X(6) H(5) I(4) N(3) Z(2) V(1) C(0). After an update, bits 7..4 of `ccr_q` equal bits 7..4 of `ccr_in`.
- R4: `wide`=0 selects a byte operation using bits 7..0 of `opa`, `opb` and `res`, and upper bits are ignored. `wide`=1 selects a word operation using bits 15..0. N is the MSB of the selected result.
- R5: Z is set exactly when the selected result bits are all zero.
- R6: Add (`op_cls`=2'b00): C is the MSB of (a&b)|(b&~r)|(a&~r).
- R7: Add: V is the MSB of (a&b&~r)|(~a&~b&r).
- R8: Subtract (`op_cls`=2'b01): C, the borrow, is the MSB of (~a&b)|(b&r)|(~a&r).
- R9: Subtract: V is the MSB of (a&~b&~r)|(~a&b&r).
- R10: Test (`op_cls`=2'b10): V is cleared, N and Z follow the result, and C is copied from `ccr_in` bit 0.
- R11: Shift (`op_cls`=2'b11): N and Z follow the result, V equals the new N XOR `ccr_in` bit 0, and C is copied from `ccr_in` bit 0.
- R12: The updated value appears on `ccr_q` after the clock edge that samples `upd_en` high, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | Capture the new flag value on this edge |
| op_cls | input | 2 | Update rule: 00 add, 01 subtract, 10 test, 11 shift |
| wide | input | 1 | 0 byte, 1 word |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| res | input | 16 | ALU result |
| ccr_in | input | 8 | Current flag register |
| ccr_q | output | 8 | Registered updated flag register |

## Verification
The bench targets the sign-boundary cases:
- A byte add of 7F+01. A design that looked at the wrong width would report no overflow there.
- Word and byte adds that wrap to zero. A swapped carry term would lose the carry on these.
- Subtracts that borrow without overflowing and that overflow without borrowing. A design with the non-borrow carry convention would invert C on both.

The test and shift rules are driven with carry-in both set and clear. This catches a V that is not cleared, or that is XORed with the new carry rather than the old one. Byte operations carry non-zero upper bytes, which would corrupt N and Z if the width mux were wrong. Update-enable-low cycles and the cycle before the capturing edge show any premature or spurious change of `ccr_q`.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
   localparam int CCR_W = 8;

   // flag bit positions (upper four pass through)
   localparam int BIT_S = 7;
   localparam int BIT_X = 6;
   localparam int BIT_H = 5;
   localparam int BIT_I = 4;
   localparam int BIT_N = 3;
   localparam int BIT_Z = 2;
   localparam int BIT_V = 1;
   localparam int BIT_C = 0;

   localparam logic [CCR_W-1:0] NZVC_MASK =
      CCR_W'((1 << BIT_N) | (1 << BIT_Z) | (1 << BIT_V) | (1 << BIT_C));

   typedef enum logic [1:0] {
      CLS_ADD = 2'b00,
      CLS_SUB = 2'b01,
      CLS_TST = 2'b10,
      CLS_SHF = 2'b11
   } op_cls_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } nzvc_t;
endpackage

// File: rtl/ccr_lane.sv
module ccr_lane
   import ccr_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] r,
   input  op_cls_e      cls,
   input  logic         c_old,
   output nzvc_t        flg
);
   localparam int MSB = W - 1;

   logic [W-1:0] add_c_vec, add_v_vec, sub_c_vec, sub_v_vec;
   logic         neg, zero;

   assign neg  = r[MSB];
   assign zero = (r == '0);

   assign add_c_vec = (a & b) | (b & ~r) | (a & ~r);
   assign add_v_vec = (a & b & ~r) | (~a & ~b & r);
   assign sub_c_vec = (~a & b) | (b & r) | (~a & r);
   assign sub_v_vec = (a & ~b & ~r) | (~a & b & r);

   always_comb begin
      flg.n = neg;
      flg.z = zero;
      unique case (cls)
         CLS_ADD: begin
            flg.c = add_c_vec[MSB];
            flg.v = add_v_vec[MSB];
         end
         CLS_SUB: begin
            flg.c = sub_c_vec[MSB];
            flg.v = sub_v_vec[MSB];
         end
         CLS_TST: begin
            flg.c = c_old;
            flg.v = 1'b0;
         end
         default: begin
            flg.c = c_old;
            flg.v = neg ^ c_old;
         end
      endcase
   end

   // R5
   always_comb begin
      z_n_excl_chk: assert (!(flg.z && flg.n) || $isunknown(r));
   end
endmodule

// File: rtl/ccr_merge.sv
module ccr_merge
   import ccr_pkg::*;
(
   input  logic [CCR_W-1:0] base,
   input  nzvc_t            flg,
   output logic [CCR_W-1:0] merged
);
   logic [CCR_W-1:0] ins;

   always_comb begin
      ins        = '0;
      ins[BIT_N] = flg.n;
      ins[BIT_Z] = flg.z;
      ins[BIT_V] = flg.v;
      ins[BIT_C] = flg.c;
   end

   // clear the flag field, then insert the new values
   assign merged = (base & ~NZVC_MASK) | ins;
endmodule

// File: rtl/ccr_flag_unit.sv
module ccr_flag_unit
   import ccr_pkg::*;
#(
   parameter int               DATA_W   = 16,
   parameter int               NARROW_W = 8,
   parameter logic [CCR_W-1:0] RST_CCR  = 8'hD0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_en,
   input  logic [1:0]        op_cls,
   input  logic              wide,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [DATA_W-1:0] res,
   input  logic [CCR_W-1:0]  ccr_in,
   output logic [CCR_W-1:0]  ccr_q
);
   localparam int N_LANES = 2;

   if (NARROW_W >= DATA_W) begin : g_bad_w
      $error("NARROW_W must be smaller than DATA_W");
   end
   if (NARROW_W < 2) begin : g_bad_n
      $error("NARROW_W must be at least 2");
   end

   op_cls_e          cls;
   nzvc_t            lane_flg [N_LANES];
   nzvc_t            sel_flg;
   logic [CCR_W-1:0] ccr_nxt;

   assign cls = op_cls_e'(op_cls);

   for (genvar i = 0; i < N_LANES; i++) begin : g_lane
      localparam int LW = (i == 0) ? NARROW_W : DATA_W;
      ccr_lane #(.W(LW)) u_lane (
         .a     (opa[LW-1:0]),
         .b     (opb[LW-1:0]),
         .r     (res[LW-1:0]),
         .cls   (cls),
         .c_old (ccr_in[BIT_C]),
         .flg   (lane_flg[i])
      );
   end

   assign sel_flg = wide ? lane_flg[1] : lane_flg[0];

   ccr_merge u_merge (
      .base   (ccr_in),
      .flg    (sel_flg),
      .merged (ccr_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ccr_q <= RST_CCR;
      else if (upd_en) ccr_q <= ccr_nxt;
   end

   // R2
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> $stable(ccr_q));

   // R3
   upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> ccr_q[CCR_W-1:BIT_I] == $past(ccr_in[CCR_W-1:BIT_I]));

   // R10
   tst_v_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && cls == CLS_TST) |=>
         (!ccr_q[BIT_V] && ccr_q[BIT_C] == $past(ccr_in[BIT_C])));

   // R11
   shf_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && cls == CLS_SHF) |=>
         (ccr_q[BIT_V] == (ccr_q[BIT_N] ^ $past(ccr_in[BIT_C]))));
endmodule

// File: tb/sim_ccr_flag_unit.sv
`timescale 1ns/1ps
module sim_ccr_flag_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        upd_en = 1'b0;
   logic [1:0]  op_cls = 2'b00;
   logic        wide = 1'b0;
   logic [15:0] opa = '0, opb = '0, res = '0;
   logic [7:0]  ccr_in = '0;
   logic [7:0]  ccr_q;

   int n_run = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   ccr_flag_unit u0 (
      .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_cls(op_cls),
      .wide(wide), .opa(opa), .opb(opb), .res(res),
      .ccr_in(ccr_in), .ccr_q(ccr_q)
   );

   // {op, wide, a, b, r, ccr_in, expected}
   localparam int NV = 14;
   localparam logic [66:0] VEC [NV] = '{
      {2'b00, 1'b0, 16'hAB7F, 16'h0001, 16'h5580, 8'h00, 8'h0A}, // R7 R4
      {2'b00, 1'b0, 16'h00FF, 16'h0001, 16'h0000, 8'hF0, 8'hF5}, // R6 R5
      {2'b00, 1'b1, 16'h8000, 16'h8000, 16'h0000, 8'h0F, 8'h07}, // R6 R7
      {2'b00, 1'b1, 16'h1234, 16'h1111, 16'h2345, 8'h5F, 8'h50}, // R3
      {2'b01, 1'b0, 16'h0000, 16'h0001, 16'h00FF, 8'h00, 8'h09}, // R8
      {2'b01, 1'b0, 16'h0080, 16'h0001, 16'h007F, 8'hA0, 8'hA2}, // R9
      {2'b01, 1'b1, 16'h0005, 16'h0005, 16'h0000, 8'h0B, 8'h04}, // R8 R5
      {2'b01, 1'b1, 16'h7FFF, 16'hFFFF, 16'h8000, 8'h00, 8'h0B}, // R8 R9
      {2'b10, 1'b1, 16'h0000, 16'h0000, 16'h8000, 8'h03, 8'h09}, // R10
      {2'b10, 1'b0, 16'h0000, 16'h0000, 16'h1200, 8'h0A, 8'h04}, // R10 R4
      {2'b11, 1'b0, 16'h0000, 16'h0000, 16'h0080, 8'h01, 8'h09}, // R11
      {2'b11, 1'b1, 16'h0000, 16'h0000, 16'h8000, 8'h00, 8'h0A}, // R11
      {2'b11, 1'b1, 16'h0000, 16'h0000, 16'h0000, 8'hE1, 8'hE7}, // R11 R3
      {2'b10, 1'b1, 16'h0000, 16'h0000, 16'h0001, 8'hFF, 8'hF1}  // R10 R3
   };

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: ccr_q=%02h expected=%02h", req, act, exp);
      end
   endtask

   initial begin
      #2000000;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", ccr_q, 8'hD0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", ccr_q, 8'hD0);

      for (int i = 0; i < NV; i++) begin
         {op_cls, wide, opa, opb, res, ccr_in} = VEC[i][66:8];
         upd_en = 1'b1;
         @(negedge clk);
         upd_en = 1'b0;
         check($sformatf("vec%0d", i), ccr_q, VEC[i][7:0]);
      end

      // R2: enable low, inputs change, value held
      op_cls = 2'b00; wide = 1'b0; opa = 16'h00FF; opb = 16'h0001;
      res = 16'h0000; ccr_in = 8'h33; upd_en = 1'b0;
      repeat (3) @(negedge clk);
      check("R2", ccr_q, 8'hF1);

      // R12: not visible before the capturing edge
      upd_en = 1'b1;
      #1;
      check("R12", ccr_q, 8'hF1);
      @(negedge clk);
      upd_en = 1'b0;
      check("R12", ccr_q, 8'h35);

      // R4: byte mode ignores upper result bits for N
      op_cls = 2'b10; wide = 1'b0; res = 16'h8001; ccr_in = 8'h00; upd_en = 1'b1;
      @(negedge clk);
      upd_en = 1'b0;
      check("R4", ccr_q, 8'h00);

      // R1: reset again restores reset value
      rst_n = 1'b0;
      #1;
      check("R1", ccr_q, 8'hD0);
      @(negedge clk);
      rst_n = 1'b1;

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule